// File: doc/BRIEF.md
# Deglitching Edge Transition Detector

This block watches a single sampled bit while an external phase value is stepped upward, one sample per step. It finds the phase at which the bit settles to a chosen level. A transition counts only when a clean run of samples at the opposite level is followed by a clean run at the chosen level. Isolated flips caused by jitter therefore restart the run rather than produce a false result.

A calibration controller uses two instances, one set to look for the bit going high and one set to look for it going low. For each instance the controller pulses the start strobe, then presents one sample per phase step, and reads the done flag and the recorded phase. The recorded phase is referred back to the step where the confirming run began. It is the phase of the confirming sample minus the run length times the phase step.

Top module: `edge_transition_detector`

## Requirements
- R1: After reset `found_o` is 0 and `edge_phase_o` is 0.
- R2: In the arming stage, a sample whose bit differs from the target level adds one to a run count, and a sample equal to the target clears it. Five consecutive differing samples (RUN_LEN) arm the detector and clear the count. Fewer never arm it.
- R3: Once armed, a sample equal to the target adds one to the run count and a differing sample clears it. `found_o` rises on the clock edge that takes the fifth consecutive matching sample, and not earlier.
- R4: On that edge `edge_phase_o` takes the signed value `phase_i − RUN_LEN × STEP_PS` (500 by default), where `phase_i` is the phase given with the confirming sample. Results may be negative.
- R5: Once `found_o` is 1, it stays 1 and `edge_phase_o` keeps its value for every later sample, whatever the bit, until start.
- R6: The target level is 1 when `polarity_i` is any nonzero value, and 0 when `polarity_i` is 0.
- R7: A cycle with `start_i` high returns the detector to the arming stage with a cleared count. On the next edge `found_o` becomes 0 and `edge_phase_o` becomes 0. Start takes priority over a sample presented in the same cycle.
- R8: On cycles with `sample_vld_i` low and `start_i` low, no state changes, whatever `flip_i` and `phase_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the search |
| sample_vld_i | input | 1 | A sample is presented this cycle |
| flip_i | input | 1 | Sampled bit |
| phase_i | input | PHASE_W | Signed phase of this sample, in ps |
| polarity_i | input | 2 | Target level select (nonzero selects 1) |
| found_o | output | 1 | Transition confirmed |
| edge_phase_o | output | PHASE_W | Signed, back-corrected transition phase |

## Verification
The main sweep presents every combination of 0 to 7 inactive samples followed by 0 to 7 active samples. It runs this for all four polarity codes and for a positive and a negative phase base. This separates arming too early or too late from confirming too early or too late, and shows that the back-correction is signed. Directed sequences add a single glitch in each stage, which tells a count that restarts apart from one that only pauses. Further sequences cover idle cycles with a toggling bit, samples taken after done, and start given together with a sample.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;

    typedef enum logic [1:0] {
        ST_ARMING = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FOUND  = 2'd2
    } det_state_e;

endpackage

// File: rtl/edge_det_run_cnt.sv
// Next value of a consecutive-sample run counter and its "run complete" flag.
module edge_det_run_cnt #(
    parameter int RUN_LEN = 5,
    parameter int CNT_W   = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             full_o
);
    logic [CNT_W:0] inc;

    always_comb begin
        inc        = {1'b0, cnt_i} + 1'b1;
        cnt_next_o = hit_i ? inc[CNT_W-1:0] : '0;
        full_o     = hit_i && (int'(inc) >= RUN_LEN);
    end
endmodule

// File: rtl/edge_det_phase_fix.sv
// Refers the confirming phase back to the start of the confirming run.
module edge_det_phase_fix #(
    parameter int PHASE_W = 32,
    parameter int RUN_LEN = 5,
    parameter int STEP_PS = 100
) (
    input  logic signed [PHASE_W-1:0] phase_i,
    output logic signed [PHASE_W-1:0] phase_o
);
    localparam logic signed [PHASE_W-1:0] OFFSET = PHASE_W'(RUN_LEN * STEP_PS);

    always_comb begin
        phase_o = phase_i - OFFSET;
    end
endmodule

// File: rtl/edge_transition_detector.sv
module edge_transition_detector
    import edge_det_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int RUN_LEN = 5,
    parameter int STEP_PS = 100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      sample_vld_i,
    input  logic                      flip_i,
    input  logic signed [PHASE_W-1:0] phase_i,
    input  logic [1:0]                polarity_i,
    output logic                      found_o,
    output logic signed [PHASE_W-1:0] edge_phase_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        det_state_e                st;
        logic [CNT_W-1:0]          cnt;
        logic signed [PHASE_W-1:0] phase;
    } det_regs_t;

    det_regs_t regs_d, regs_q;

    logic                      target;
    logic                      hit;
    logic [CNT_W-1:0]          cnt_next;
    logic                      run_full;
    logic signed [PHASE_W-1:0] phase_fixed;

    edge_det_run_cnt #(
        .RUN_LEN (RUN_LEN),
        .CNT_W   (CNT_W)
    ) u_run_cnt (
        .cnt_i      (regs_q.cnt),
        .hit_i      (hit),
        .cnt_next_o (cnt_next),
        .full_o     (run_full)
    );

    edge_det_phase_fix #(
        .PHASE_W (PHASE_W),
        .RUN_LEN (RUN_LEN),
        .STEP_PS (STEP_PS)
    ) u_phase_fix (
        .phase_i (phase_i),
        .phase_o (phase_fixed)
    );

    always_comb begin
        target = |polarity_i;
        // arming stage counts off-target samples, armed stage counts on-target ones
        hit    = (regs_q.st == ST_ARMING) ? (flip_i != target) : (flip_i == target);
        regs_d = regs_q;
        if (start_i) begin
            regs_d.st    = ST_ARMING;
            regs_d.cnt   = '0;
            regs_d.phase = '0;
        end else if (sample_vld_i) begin
            unique case (regs_q.st)
                ST_ARMING: begin
                    if (run_full) begin
                        regs_d.st  = ST_ARMED;
                        regs_d.cnt = '0;
                    end else begin
                        regs_d.cnt = cnt_next;
                    end
                end
                ST_ARMED: begin
                    regs_d.cnt = cnt_next;
                    if (run_full) begin
                        regs_d.st    = ST_FOUND;
                        regs_d.phase = phase_fixed;
                    end
                end
                default: begin
                    regs_d = regs_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_ARMING, cnt: '0, phase: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign found_o      = (regs_q.st == ST_FOUND);
    assign edge_phase_o = regs_q.phase;
endmodule

// File: rtl/edge_det_checker.sv
module edge_det_checker #(
    parameter int PHASE_W = 32,
    parameter int RUN_LEN = 5,
    parameter int STEP_PS = 100
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      sample_vld_i,
    input logic                      flip_i,
    input logic signed [PHASE_W-1:0] phase_i,
    input logic                      found_o,
    input logic signed [PHASE_W-1:0] edge_phase_o
);
    localparam logic signed [PHASE_W-1:0] OFFSET = PHASE_W'(RUN_LEN * STEP_PS);

    // R5
    found_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !start_i) |=> (found_o && $stable(edge_phase_o)));

    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!found_o && edge_phase_o == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !sample_vld_i) |=> ($stable(found_o) && $stable(edge_phase_o)));

    // R4
    phase_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found_o) |-> (edge_phase_o == $past(phase_i) - OFFSET));

    // R3
    found_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found_o) |-> ($past(sample_vld_i) && !$past(start_i)));
endmodule

bind edge_transition_detector edge_det_checker #(
    .PHASE_W (PHASE_W),
    .RUN_LEN (RUN_LEN),
    .STEP_PS (STEP_PS)
) u_edge_det_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sample_vld_i (sample_vld_i),
    .flip_i       (flip_i),
    .phase_i      (phase_i),
    .found_o      (found_o),
    .edge_phase_o (edge_phase_o)
);

// File: tb/test_edge_transition_detector.sv
`timescale 1ns/1ps
module test_edge_transition_detector;
    localparam int PW   = 32;
    localparam int RUN  = 5;
    localparam int STEP = 100;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 sample_vld_i = 1'b0;
    logic                 flip_i = 1'b0;
    logic signed [PW-1:0] phase_i = '0;
    logic [1:0]           polarity_i = 2'd0;
    logic                 found_o;
    logic signed [PW-1:0] edge_phase_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    edge_transition_detector #(.PHASE_W(PW), .RUN_LEN(RUN), .STEP_PS(STEP)) i_edge_transition_detector (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_vld_i(sample_vld_i),
        .flip_i(flip_i), .phase_i(phase_i), .polarity_i(polarity_i),
        .found_o(found_o), .edge_phase_o(edge_phase_o)
    );

    task automatic check(input string req, input logic exp_found, input int exp_phase, input logic cmp_phase);
        checks++;
        if (found_o !== exp_found || (cmp_phase && edge_phase_o !== exp_phase)) begin
            errors++;
            $display("FAIL %s: found=%0b phase=%0d expected found=%0b phase=%0d",
                     req, found_o, edge_phase_o, exp_found, exp_phase);
        end
    endtask

    // all drives happen at negedge; the rising edge in between samples them
    task automatic restart();
        start_i = 1'b1; sample_vld_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic sample(input logic b, input int ph);
        sample_vld_i = 1'b1; flip_i = b; phase_i = ph;
        @(negedge clk);
        sample_vld_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic tgt;
        int base, idx;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 0, 1'b1);

        // R2 R3 R4 R6 sweep: k inactive samples then m active samples
        for (int pol = 0; pol < 4; pol++) begin
            for (int bsel = 0; bsel < 2; bsel++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int m = 0; m < 8; m++) begin
                        polarity_i = 2'(pol);
                        tgt  = (pol != 0);
                        base = (bsel == 0) ? 2000 : -1000;
                        restart();
                        idx = 0;
                        for (int i = 0; i < k; i++) begin
                            sample(~tgt, base + idx * STEP); idx++;
                            check("R2 no found during inactive run", 1'b0, 0, 1'b0);
                        end
                        for (int j = 0; j < m; j++) begin
                            sample(tgt, base + idx * STEP); idx++;
                            check("R3 R6 found timing", (k >= RUN) && (j >= RUN - 1), 0, 1'b0);
                        end
                        if (k >= RUN && m >= RUN)
                            check("R4 back-corrected phase", 1'b1, base + (k - 1) * STEP, 1'b1);
                        else
                            check("R2 R3 no confirmation", 1'b0, 0, 1'b1);
                    end
                end
            end
        end

        // R2 glitch while arming: 3 off, 1 on, 5 off, 5 on -> confirm at index 13
        polarity_i = 2'd1; restart();
        idx = 0;
        for (int i = 0; i < 3; i++) begin sample(1'b0, idx * STEP); idx++; end
        sample(1'b1, idx * STEP); idx++;
        for (int i = 0; i < 5; i++) begin sample(1'b0, idx * STEP); idx++; end
        for (int i = 0; i < 4; i++) begin sample(1'b1, idx * STEP); idx++; end
        check("R2 glitch restarts arming run", 1'b0, 0, 1'b1);
        sample(1'b1, idx * STEP);
        check("R2 glitch then confirm", 1'b1, 13 * STEP - RUN * STEP, 1'b1);

        // R3 glitch while armed: 5 off, 4 on, 1 off, 5 on -> confirm at index 14
        polarity_i = 2'd0; restart();
        idx = 0;
        for (int i = 0; i < 5; i++) begin sample(1'b1, idx * STEP); idx++; end
        for (int i = 0; i < 4; i++) begin sample(1'b0, idx * STEP); idx++; end
        sample(1'b1, idx * STEP); idx++;
        for (int i = 0; i < 4; i++) begin sample(1'b0, idx * STEP); idx++; end
        check("R3 glitch restarts confirm run", 1'b0, 0, 1'b1);
        sample(1'b0, idx * STEP);
        check("R3 glitch then confirm", 1'b1, 14 * STEP - RUN * STEP, 1'b1);

        // R5: later samples of either level keep result
        for (int i = 0; i < 8; i++) begin
            sample(i[0], 99999 + i);
            check("R5 sticky result", 1'b1, 14 * STEP - RUN * STEP, 1'b1);
        end

        // R8: idle cycles with a toggling bit, mid-run
        polarity_i = 2'd2; restart();
        for (int i = 0; i < 5; i++) sample(1'b0, i * STEP);
        for (int i = 0; i < 4; i++) sample(1'b1, 500 + i * STEP);
        for (int i = 0; i < 6; i++) begin
            flip_i = i[0]; phase_i = 7777;
            @(negedge clk);
            check("R8 idle cycle no change", 1'b0, 0, 1'b1);
        end
        sample(1'b1, 900);
        check("R8 run kept across idle cycles", 1'b1, 400, 1'b1);
        for (int i = 0; i < 3; i++) begin
            flip_i = ~flip_i; phase_i = -5;
            @(negedge clk);
            check("R8 idle after found", 1'b1, 400, 1'b1);
        end

        // R7: start together with a confirming sample wins
        polarity_i = 2'd3; restart();
        for (int i = 0; i < 5; i++) sample(1'b0, 0);
        for (int i = 0; i < 4; i++) sample(1'b1, 0);
        start_i = 1'b1; sample_vld_i = 1'b1; flip_i = 1'b1; phase_i = 3000;
        @(negedge clk);
        start_i = 1'b0; sample_vld_i = 1'b0;
        check("R7 start beats sample", 1'b0, 0, 1'b1);
        sample(1'b1, 3000);
        check("R7 count cleared by start", 1'b0, 0, 1'b1);
        // R7: start after found clears result
        for (int i = 0; i < 5; i++) sample(1'b0, 0);
        for (int i = 0; i < 5; i++) sample(1'b1, 600 + i * STEP);
        check("R7 found before start", 1'b1, 500, 1'b1);
        restart();
        check("R7 start clears result", 1'b0, 0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule